// File: doc/BRIEF.md
# FSK Zero-Crossing Interval Demodulator

This block turns a two-tone frequency-shift-keyed signal back into a serial bit stream. An external comparator has already squared the signal up to a single logic bit. A divider derives a slow sample tick from the system clock. On each tick an interval counter advances, and every edge of the squared input is judged by how many ticks have passed since the last accepted edge. Edges of either polarity count, so the counter measures half-periods.

A half-period in the short window marks the higher tone, which is data 0, and drives the data output low. A counter that reaches the long-tone threshold drives the data output high, which is data 1. The data output is a raw level, and a downstream UART samples it at the agreed baud rate. A status LED output is always the inverse of the data output. Very short pulses are taken as glitches and do not restart the measurement. Intervals that are too short or too long only restart it.

With the default tick of 163 clocks at 50 MHz, the tick rate is about 306.7 kHz. The windows then fit a 2100 Hz high tone and a 1300 Hz low tone.

Top module: `fsk_zc_demod`

## Requirements
- R1: After reset, data_o is 1 and led_o is 0. The interval count and the stored previous input sample are both 0.
- R2: Work happens only on a sample tick. The first tick comes CLK_DIV clocks after reset is released, and ticks repeat every CLK_DIV clocks. cmp_i passes through a two-flop synchronizer first. Between ticks, the outputs do not change.
- R3: On each enabled tick, the count is incremented first. If the new count is 95 or more, data_o goes to 1 and led_o goes to 0, whether or not an edge occurred.
- R4: An edge is a synchronized sample that differs from the stored previous sample, rising or falling. An edge with a new count below 20 is a glitch. The count keeps running without a restart, and the stored sample takes the new level.
- R5: An edge with a new count from 20 to 39 restarts the count at 0 and leaves the outputs unchanged.
- R6: An edge with a new count from 40 to 94 sets data_o to 0 and led_o to 1, and restarts the count at 0.
- R7: An edge with a new count from 95 to 139 restarts the count at 0. The outputs stay at the level that R3 already set (data_o 1).
- R8: An edge with a new count of 140 or more restarts the count at 0 and leaves the outputs unchanged.
- R9: On a tick that would carry the 8-bit count past 255, the count is cleared. The stored sample takes the current level, and the outputs are left unchanged.
- R10: While en_i is 0, ticks have no effect. The count, the stored sample and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receiver enable; 0 freezes all state |
| cmp_i | input | 1 | Squared-up comparator bit, asynchronous |
| data_o | output | 1 | Recovered data level (1 = low tone / idle) |
| led_o | output | 1 | Status indicator, inverse of data_o |

## Verification
A wrong count shows at the ports within one interval. A missed restart or a wrongly restarted glitch moves the next edge into a different window. That changes data_o on the tick where the edge lands, or on the tick where the count crosses 95. A stale previous sample gives a missed or extra edge, and this flips the decision on the next tick. An enable or tick gating fault moves an output change away from a tick edge. The bench therefore models the rules per tick and compares both outputs at every tick and between ticks.

// File: rtl/fsk_demod_pkg.sv
package fsk_demod_pkg;

  typedef enum logic [2:0] {
    IV_GLITCH,
    IV_SHORT,
    IV_HIGH,
    IV_LOW,
    IV_LONG
  } iv_class_e;

endpackage

// File: rtl/fsk_tick_gen.sv
module fsk_tick_gen #(
  parameter int CLK_DIV = 163
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + DW'(1);
  end

  assign tick_o = (div_q == LAST);

endmodule

// File: rtl/fsk_sync.sv
module fsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fsk_iv_classify.sv
module fsk_iv_classify
  import fsk_demod_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int GLITCH_TH = 20,
  parameter int SHORT_TH  = 40,
  parameter int LOW_TH    = 95,
  parameter int LONG_TH   = 140
) (
  input  logic [CNT_W-1:0] cnt_i,
  output iv_class_e        cls_o
);

  localparam logic [CNT_W-1:0] GL_C = CNT_W'(GLITCH_TH);
  localparam logic [CNT_W-1:0] SH_C = CNT_W'(SHORT_TH);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LOW_TH);
  localparam logic [CNT_W-1:0] LG_C = CNT_W'(LONG_TH);

  always_comb begin
    if (cnt_i < GL_C)      cls_o = IV_GLITCH;
    else if (cnt_i < SH_C) cls_o = IV_SHORT;
    else if (cnt_i < LO_C) cls_o = IV_HIGH;
    else if (cnt_i < LG_C) cls_o = IV_LOW;
    else                   cls_o = IV_LONG;
  end

endmodule

// File: rtl/fsk_zc_demod.sv
module fsk_zc_demod
  import fsk_demod_pkg::*;
#(
  parameter int CLK_DIV     = 163,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int GLITCH_TH   = 20,
  parameter int SHORT_TH    = 40,
  parameter int LOW_TH      = 95,
  parameter int LONG_TH     = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_i,
  output logic data_o,
  output logic led_o
);

  localparam logic [CNT_W-1:0] LO_C = CNT_W'(LOW_TH);

  logic             tick;
  logic             smp;
  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_sum;
  logic [CNT_W-1:0] cnt_nx;
  logic             wrap;
  logic             edge_det;
  logic             data_q;
  logic             led_q;
  iv_class_e        cls;

  fsk_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  fsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (smp)
  );

  assign cnt_sum  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap     = cnt_sum[CNT_W];
  assign cnt_nx   = cnt_sum[CNT_W-1:0];
  assign edge_det = smp ^ prev_q;

  fsk_iv_classify #(
    .CNT_W    (CNT_W),
    .GLITCH_TH(GLITCH_TH),
    .SHORT_TH (SHORT_TH),
    .LOW_TH   (LOW_TH),
    .LONG_TH  (LONG_TH)
  ) u_cls (
    .cnt_i(cnt_nx),
    .cls_o(cls)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
      data_q <= 1'b1;
      led_q  <= 1'b0;
    end else if (tick && en_i) begin
      if (wrap) begin
        // counter overflow: restart, resync edge history, outputs untouched
        cnt_q  <= '0;
        prev_q <= smp;
      end else begin
        if (cnt_nx >= LO_C) begin
          data_q <= 1'b1;
          led_q  <= 1'b0;
        end
        if (edge_det) begin
          prev_q <= smp;
          unique case (cls)
            IV_GLITCH: cnt_q <= cnt_nx;
            IV_HIGH: begin
              data_q <= 1'b0;
              led_q  <= 1'b1;
              cnt_q  <= '0;
            end
            default: cnt_q <= '0;
          endcase
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  assign data_o = data_q;
  assign led_o  = led_q;

endmodule

// File: rtl/fsk_zc_demod_chk.sv
module fsk_zc_demod_chk #(
  parameter int CNT_W     = 8,
  parameter int GLITCH_TH = 20,
  parameter int LOW_TH    = 95
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             tick,
  input logic             edge_det,
  input logic [CNT_W-1:0] cnt_q,
  input logic             data_o,
  input logic             led_o
);

  localparam logic [CNT_W-1:0] GL_M1 = CNT_W'(GLITCH_TH - 1);
  localparam logic [CNT_W-1:0] LO_M1 = CNT_W'(LOW_TH - 1);

  // R1
  led_inverse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_o == !data_o);

  // R2
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(data_o) && $stable(cnt_q));

  // R10
  enable_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(data_o) && $stable(cnt_q));

  // R3
  timeout_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && en_i && cnt_q >= LO_M1 && cnt_q != '1) |=> data_o);

  // R4
  glitch_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && en_i && edge_det && cnt_q < GL_M1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R9
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && en_i && cnt_q == '1) |=> cnt_q == '0 && $stable(data_o));

endmodule

bind fsk_zc_demod fsk_zc_demod_chk #(
  .CNT_W    (CNT_W),
  .GLITCH_TH(GLITCH_TH),
  .LOW_TH   (LOW_TH)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .tick    (tick),
  .edge_det(edge_det),
  .cnt_q   (cnt_q),
  .data_o  (data_o),
  .led_o   (led_o)
);

// File: tb/tb_fsk_zc_demod.sv
module tb_fsk_zc_demod;

  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic cmp_i = 1'b0;
  logic data_o, led_o;

  int checks = 0;
  int failures = 0;

  // requirement-level model, one step per tick
  int   m_cnt = 0;
  logic m_prev = 1'b0;
  logic m_d = 1'b1;
  logic m_l = 1'b0;
  logic cur = 1'b0;

  always #10 clk = ~clk;

  fsk_zc_demod #(.CLK_DIV(DIV)) dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .cmp_i (cmp_i),
    .data_o(data_o),
    .led_o (led_o)
  );

  task automatic check(input string tag, input logic ed, input logic el);
    checks++;
    if (data_o !== ed || led_o !== el) begin
      failures++;
      $display("FAIL %s data_o=%b led_o=%b expected data_o=%b led_o=%b",
               tag, data_o, led_o, ed, el);
    end
  endtask

  task automatic model_tick(input logic s);
    int n;
    if (!en_i) return;
    if (m_cnt == 255) begin
      m_cnt = 0;
      m_prev = s;
    end else begin
      n = m_cnt + 1;
      if (n >= 95) begin m_d = 1'b1; m_l = 1'b0; end
      if (s != m_prev) begin
        m_prev = s;
        if (n < 20) m_cnt = n;
        else begin
          if (n >= 40 && n < 95) begin m_d = 1'b0; m_l = 1'b1; end
          m_cnt = 0;
        end
      end else m_cnt = n;
    end
  endtask

  // one tick period with cmp_i held at lvl; starts and ends at a negedge
  task automatic step(input logic lvl, input string tag);
    cmp_i = lvl;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R2 mid-period"}, m_d, m_l);
    repeat (DIV - 1) @(posedge clk);
    @(negedge clk);
    model_tick(lvl);
    check(tag, m_d, m_l);
  endtask

  task automatic interval(input int h, input string tag);
    cur = ~cur;
    step(cur, tag);
    for (int i = 1; i < h; i++) step(cur, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 1'b1, 1'b0);
    rst_ni = 1'b1;
    en_i = 1'b1;
    for (int i = 0; i < 5; i++) step(cur, "R1");

    for (int i = 0; i < 3; i++) interval(10, "R4 glitch");
    for (int i = 0; i < 4; i++) interval(60, "R6 high tone");
    interval(60, "R6 high tone");
    interval(130, "R3 timeout to mark");
    for (int i = 0; i < 3; i++) interval(120, "R7 low tone");
    interval(60, "R6 high tone");
    interval(30, "R5 too short");
    interval(70, "R5 restart after short");
    interval(60, "R6 high tone");
    interval(200, "R8 too long");
    interval(50, "R8 restart after long");
    interval(300, "R9 wrap clears");
    interval(45, "R9 after wrap");

    interval(60, "R6 before disable");
    en_i = 1'b0;
    for (int i = 0; i < 40; i++) step((i % 7) < 3, "R10 disabled");
    cur = 1'b0;
    for (int i = 0; i < 5; i++) step(cur, "R10 disabled");
    en_i = 1'b1;
    for (int i = 0; i < 20; i++) step(cur, "R10 re-enabled");
    interval(70, "R10 re-enabled");

    for (int h = 1; h <= 150; h++) begin
      string tag;
      if (h < 20)       tag = "R4 sweep";
      else if (h < 40)  tag = "R5 sweep";
      else if (h < 95)  tag = "R6 sweep";
      else if (h < 140) tag = "R7 sweep";
      else              tag = "R8 sweep";
      interval(h, tag);
      interval(h, tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule